// File: doc/BRIEF.md
# Retriggerable Monostable Pulse Generator

This block is a clocked replacement for a retriggerable one-shot. Three control inputs arrive from outside the clock domain: an active-low trigger, an active-high trigger and an active-low clear. Each passes through a two-flop synchroniser. The block then looks for edges by comparing each synchronised sample with the one taken a cycle earlier. A qualifying edge loads a down-counter with the programmed width, given in clock cycles. The output stays high while that counter is non-zero, and a second output always carries its complement.

Each of the three inputs can start a pulse, but only while the other two sit at their enabling levels. A trigger that arrives during an active pulse reloads the full width, so the pulse is stretched rather than ignored. A trigger train whose period is shorter than the width therefore holds the output high without a break. Holding clear low forces the outputs idle at once and cuts any running pulse. When clear is released while the other two inputs enable triggering, that release starts a new pulse.

Top module: `pulse_oneshot`

## Requirements
- R1: A falling edge on `trig_a_n_i` (bit value 1 to 0) starts a pulse only while `trig_b_i` is 1 and `clr_n_i` is 1.
- R2: A rising edge on `trig_b_i` starts a pulse only while `trig_a_n_i` is 0 and `clr_n_i` is 1.
- R3: A rising edge on `clr_n_i` starts a pulse when `trig_a_n_i` is 0 and `trig_b_i` is 1.
- R4: While `clr_n_i` is 0, `q_o` is 0 whatever `trig_a_n_i` and `trig_b_i` do, and a running pulse ends three clock edges after clear falls.
- R5: With `trig_a_n_i` held at 1 or `trig_b_i` held at 0, no transition on any input starts a pulse, and `q_o` stays 0.
- R6: A qualifying trigger during a pulse reloads the full width, so a retrigger d cycles after the first (d not above the width) gives one unbroken high of d + width cycles.
- R7: A trigger train whose period is shorter than the width keeps `q_o` at 1 in every cycle of the train.
- R8: `q_n_o` is the complement of `q_o` in every cycle.
- R9: A pulse lasts exactly `width_i` clock cycles, with `width_i` sampled when the trigger is taken; a width of 0 gives no pulse.
- R10: `q_o` rises on the third rising clock edge after a qualifying input transition: two synchroniser stages and one counter load.
- R11: When clear rises in the same cycle as a qualifying `trig_b_i` rise, exactly one pulse of `width_i` cycles results.
- R12: Asserting `rst_n` forces `q_o` to 0 at once, even during a pulse. After release, idle inputs (`trig_a_n_i` = 1, `trig_b_i` = 0, `clr_n_i` = 1) start no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| width_i | input | WIDTH_W | Pulse width in clock cycles |
| trig_a_n_i | input | 1 | Active-low trigger, responds to a falling edge |
| trig_b_i | input | 1 | Active-high trigger, responds to a rising edge |
| clr_n_i | input | 1 | Active-low clear; its rising edge can also trigger |
| q_o | output | 1 | Pulse output |
| q_n_o | output | 1 | Complement of q_o |

## Verification
The gating rules are swept in full. Every one of the eight steady level combinations is followed by a toggle of each single input in turn, and the measured high-cycle count is compared with the count predicted from the three trigger conditions. This sweep separates the three trigger paths from one another and from the blocked cases. A width sweep from 0 to 15 pins the pulse length. Timed sequences cover the rest: a retrigger, a dense trigger train, a clear that cuts a pulse while the triggers keep toggling, a simultaneous clear-and-trigger rise, and a reset in mid-pulse. These show the difference between extending a pulse and ignoring a trigger, and between a single combined trigger and two triggers. A direct latency probe fixes the edge on which the output first rises.

// File: rtl/oneshot_pkg.sv
`timescale 1ns/1ps
package oneshot_pkg;
  localparam int N_CTRL  = 3;
  localparam int IDX_A   = 0;  // active-low trigger
  localparam int IDX_B   = 1;  // active-high trigger
  localparam int IDX_CLR = 2;  // active-low clear
  typedef logic [N_CTRL-1:0] ctrl_t;
  // Levels assumed at reset: A high, B low, clear released
  localparam ctrl_t IDLE_LEVELS = 3'b101;
endpackage

// File: rtl/os_rst_sync.sv
`timescale 1ns/1ps
module os_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_n_o = out_q;
endmodule

// File: rtl/os_sync2.sv
`timescale 1ns/1ps
module os_sync2 #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/os_trig_detect.sv
`timescale 1ns/1ps
module os_trig_detect
  import oneshot_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  ctrl_t lv_i,
  output logic  trig_o
);
  ctrl_t prev_q;
  logic  a_fall, b_rise, clr_rise;
  logic  a_low, b_high, clr_high;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= IDLE_LEVELS;
    else        prev_q <= lv_i;
  end

  always_comb begin
    a_low    = !lv_i[IDX_A];
    b_high   = lv_i[IDX_B];
    clr_high = lv_i[IDX_CLR];
    a_fall   = prev_q[IDX_A] && a_low;
    b_rise   = !prev_q[IDX_B] && b_high;
    clr_rise = !prev_q[IDX_CLR] && clr_high;
    trig_o   = (a_fall   && b_high && clr_high)
            || (b_rise   && a_low  && clr_high)
            || (clr_rise && a_low  && b_high);
  end

  // R5: A high or B low blocks every trigger path
  assert_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lv_i[IDX_A] || !lv_i[IDX_B]) |-> !trig_o);
  // R4: no trigger while clear is low
  assert_no_trig_in_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !lv_i[IDX_CLR] |-> !trig_o);
endmodule

// File: rtl/os_width_counter.sv
`timescale 1ns/1ps
module os_width_counter #(
  parameter int WIDTH_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_s_i,
  input  logic               trig_i,
  input  logic [WIDTH_W-1:0] width_i,
  output logic               pulse_o
);
  localparam logic [WIDTH_W-1:0] CNT_ZERO = '0;
  localparam logic [WIDTH_W-1:0] CNT_ONE  = {{(WIDTH_W-1){1'b0}}, 1'b1};

  logic [WIDTH_W-1:0] cnt_q, cnt_d;
  logic               cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = !clr_s_i || trig_i || (cnt_q != CNT_ZERO);
    if (!clr_s_i)              cnt_d = CNT_ZERO;
    else if (trig_i)           cnt_d = width_i;
    else if (cnt_q != CNT_ZERO) cnt_d = cnt_q - CNT_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= CNT_ZERO;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign pulse_o = (cnt_q != CNT_ZERO);

  // R4: clear low empties the counter on the next edge
  assert_clear_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_s_i |=> (cnt_q == CNT_ZERO));
  // R6: a trigger reloads the full width, even mid-pulse
  assert_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && clr_s_i) |=> (cnt_q == $past(width_i)));
  // R9: without trigger or clear the count drops by one per cycle
  assert_count_down_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig_i && clr_s_i && cnt_q != CNT_ZERO) |=> (cnt_q == $past(cnt_q) - CNT_ONE));
endmodule

// File: rtl/pulse_oneshot.sv
`timescale 1ns/1ps
module pulse_oneshot
  import oneshot_pkg::*;
#(
  parameter int WIDTH_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [WIDTH_W-1:0] width_i,
  input  logic               trig_a_n_i,
  input  logic               trig_b_i,
  input  logic               clr_n_i,
  output logic               q_o,
  output logic               q_n_o
);
  logic  rst_n_s;
  ctrl_t raw_lv;
  ctrl_t sync_lv;
  logic  trig;
  logic  pulse;

  os_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (rst_n_s)
  );

  always_comb begin
    raw_lv          = IDLE_LEVELS;
    raw_lv[IDX_A]   = trig_a_n_i;
    raw_lv[IDX_B]   = trig_b_i;
    raw_lv[IDX_CLR] = clr_n_i;
  end

  for (genvar i = 0; i < N_CTRL; i++) begin : g_sync
    os_sync2 #(.RST_VAL(IDLE_LEVELS[i])) u_sync (
      .clk   (clk),
      .rst_n (rst_n_s),
      .d_i   (raw_lv[i]),
      .q_o   (sync_lv[i])
    );
  end

  os_trig_detect u_det (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .lv_i   (sync_lv),
    .trig_o (trig)
  );

  os_width_counter #(.WIDTH_W(WIDTH_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .clr_s_i (sync_lv[IDX_CLR]),
    .trig_i  (trig),
    .width_i (width_i),
    .pulse_o (pulse)
  );

  assign q_o   = pulse;
  assign q_n_o = ~pulse;

  // R10: a taken trigger with non-zero width shows on q_o after the next edge
  assert_pulse_after_trig_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    (trig && sync_lv[IDX_CLR] && width_i != '0) |=> q_o);
endmodule

// File: tb/tb_pulse_oneshot.sv
`timescale 1ns/1ps
module tb_pulse_oneshot;
  localparam int WIDTH_W = 8;

  logic               clk = 1'b0;
  logic               rst_n;
  logic [WIDTH_W-1:0] width;
  logic               a_n, b, clr_n;
  logic               q, qn;

  int vecs = 0;
  int bad  = 0;
  bit mon_on = 1'b0;

  always #10 clk = ~clk;

  pulse_oneshot #(.WIDTH_W(WIDTH_W)) dut (
    .clk(clk), .rst_n(rst_n), .width_i(width),
    .trig_a_n_i(a_n), .trig_b_i(b), .clr_n_i(clr_n),
    .q_o(q), .q_n_o(qn)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    vecs++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // R8: complement checked every cycle while the monitor runs
  always @(negedge clk) begin
    if (mon_on) chk(qn === ~q, "R8", "q_n_o vs q_o", int'(qn), int'(~q));
  end

  task automatic drive(input logic a, input logic bb, input logic c);
    @(negedge clk);
    a_n = a; b = bb; clr_n = c;
  endtask

  task automatic settle();
    repeat (30) @(negedge clk);
  endtask

  task automatic count_high(input int n, output int hi, output int rises);
    logic last;
    hi = 0; rises = 0; last = q;
    repeat (n) begin
      @(negedge clk);
      if (q) hi++;
      if (q && !last) rises++;
      last = q;
    end
  endtask

  initial begin : watchdog
    #(20 * 150000);
    bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin : stim
    int hi, rises, lows;
    rst_n = 1'b0; width = 8'd5;
    a_n = 1'b1; b = 1'b0; clr_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(q == 1'b0 && qn == 1'b1, "R12", "q_o in reset", int'(q), 0);
    rst_n = 1'b1;
    mon_on = 1'b1;
    count_high(20, hi, rises);
    chk(hi == 0, "R12", "no pulse after release with idle inputs", hi, 0);

    // Gating sweep: every level combination, each input toggled alone
    width = 8'd5;
    for (int s = 0; s < 8; s++) begin
      for (int t = 0; t < 3; t++) begin
        logic oa, ob, oc, na, nb, nc, exp_t;
        string tag;
        oa = s[0]; ob = s[1]; oc = s[2];
        drive(oa, ob, oc);
        settle();
        chk(q == 1'b0, "R5", "idle before toggle", int'(q), 0);
        na = oa; nb = ob; nc = oc;
        if (t == 0) na = ~oa;
        if (t == 1) nb = ~ob;
        if (t == 2) nc = ~oc;
        case (t)
          0: exp_t = oa && !na && nb && nc;
          1: exp_t = !ob && nb && !na && nc;
          default: exp_t = !oc && nc && !na && nb;
        endcase
        if (na || !nb)  tag = "R5";
        else if (t == 0) tag = "R1";
        else if (t == 1) tag = "R2";
        else             tag = "R3";
        drive(na, nb, nc);
        count_high(14, hi, rises);
        chk(hi == (exp_t ? 5 : 0), tag, $sformatf("highs s=%0d t=%0d", s, t),
            hi, exp_t ? 5 : 0);
      end
    end

    // R10: latency of the first high
    width = 8'd4;
    drive(1'b0, 1'b0, 1'b1);
    settle();
    drive(1'b0, 1'b1, 1'b1);
    @(negedge clk);
    @(negedge clk);
    chk(q == 1'b0, "R10", "q_o two edges after trigger", int'(q), 0);
    @(negedge clk);
    chk(q == 1'b1, "R10", "q_o three edges after trigger", int'(q), 1);
    settle();

    // R9: width sweep including zero
    for (int w = 0; w < 16; w++) begin
      width = w[WIDTH_W-1:0];
      drive(1'b0, 1'b0, 1'b1);
      settle();
      drive(1'b0, 1'b1, 1'b1);
      count_high(25, hi, rises);
      chk(hi == w, "R9", $sformatf("pulse length w=%0d", w), hi, w);
    end

    // R6: retrigger 4 cycles after the first, width 8
    width = 8'd8;
    drive(1'b0, 1'b0, 1'b1);
    settle();
    hi = 0; rises = 0;
    begin
      logic last;
      last = 1'b0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (q) hi++;
        if (q && !last) rises++;
        last = q;
        if (k == 0 || k == 4) b = 1'b1;
        if (k == 2) b = 1'b0;
      end
    end
    chk(hi == 12, "R6", "retriggered high cycles", hi, 12);
    chk(rises == 1, "R6", "retriggered pulse unbroken", rises, 1);

    // R7: trigger period 4 with width 8 holds q_o high
    drive(1'b0, 1'b0, 1'b1);
    settle();
    lows = 0;
    for (int k = 0; k < 63; k++) begin
      @(negedge clk);
      if (k >= 4 && !q) lows++;
      if (k < 60 && k % 4 == 0) b = 1'b1;
      if (k < 60 && k % 4 == 2) b = 1'b0;
    end
    chk(lows == 0, "R7", "low cycles during dense train", lows, 0);
    settle();

    // R4 then R3: clear cuts a pulse, triggers ignored, clear release retriggers
    width = 8'd20;
    drive(1'b0, 1'b0, 1'b1);
    settle();
    hi = 0; lows = 0;
    for (int k = 0; k < 50; k++) begin
      @(negedge clk);
      if (q && k < 20)  hi++;
      if (q && k >= 20) lows++;
      case (k)
        0:  b = 1'b1;
        5:  clr_n = 1'b0;
        10: b = 1'b0;
        12: b = 1'b1;
        14: a_n = 1'b1;
        16: a_n = 1'b0;
        20: clr_n = 1'b1;
        default: ;
      endcase
    end
    chk(hi == 5, "R4", "highs before clear cut", hi, 5);
    chk(lows == 20, "R3", "highs after clear release", lows, 20);

    // R11: clear and B rise together give one pulse
    width = 8'd6;
    drive(1'b0, 1'b0, 1'b0);
    settle();
    drive(1'b0, 1'b1, 1'b1);
    count_high(20, hi, rises);
    chk(hi == 6, "R11", "combined trigger length", hi, 6);
    chk(rises == 1, "R11", "combined trigger pulse count", rises, 1);

    // R12: reset during a pulse
    width = 8'd20;
    drive(1'b0, 1'b0, 1'b1);
    settle();
    drive(1'b0, 1'b1, 1'b1);
    repeat (6) @(negedge clk);
    chk(q == 1'b1, "R12", "pulse running before reset", int'(q), 1);
    rst_n = 1'b0;
    #1;
    chk(q == 1'b0, "R12", "q_o right after reset", int'(q), 0);
    a_n = 1'b1; b = 1'b0; clr_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    count_high(30, hi, rises);
    chk(hi == 0, "R12", "no pulse after mid-pulse reset", hi, 0);

    mon_on = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule